// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Transmitter

This block takes a two-channel serial audio stream (one data line, a bit clock and a word-select line) and recovers each left and right sample. The input framing can be left-justified, I2S or right-justified, and the word width can be 16, 18, 20 or 24 bits. It then sends the samples as a biphase-mark coded line. The line is built from subframes of 32 slots. Each subframe holds a preamble, a 24-bit audio field, three flag bits and an even-parity bit.

All inputs are sampled by the system clock `clk`. Both the bit clock and the word-select line must be slow enough for every level to be seen. The output advances by one half-cell on each cycle in which `hc_tick` is high. That strobe runs at 128 times the frame rate: 64 slots per frame, each made of two half-cells. A frame starts at half-cell 0. At that point the framer takes the latest left/right pair from the deserializer.

The framer is a state machine with three named states. ST_PREAMBLE covers slots 0 to 3. Its transition PRE_TO_AUDIO fires on the tick that ends slot 3. ST_AUDIO covers slots 4 to 27. Its transition AUDIO_TO_FLAGS fires on the tick that ends slot 27. ST_FLAGS covers slots 28 to 31. Its transition FLAGS_TO_PRE fires on the tick that ends slot 31, which starts the next subframe.

Top module: `bmc_audio_tx`

## Requirements
- R1: After reset, `bmc_out` is 0. The first `hc_tick` emits half-cell 0 of a left subframe, which carries the block-start preamble.
- R2: `bmc_out` changes only in the cycle after an `hc_tick`. Each tick emits one half-cell, and a frame is 128 half-cells: left subframe first, then right.
- R3: In slots 4 to 31 the line toggles at the start of every cell. It toggles again mid-cell exactly when the slot's bit is 1.
- R4: Slots 4 to 27 carry the 24-bit audio field, LSB first. Slot 28 (validity) and slot 29 (user) are 0. Slot 30 carries the constant parameter `CS_BIT`. Slot 31 makes the count of ones in slots 4 to 31 even.
- R5: Slots 0 to 3 carry a preamble. Block start is 11101000 and is used on the left subframe of frame 0 of every 192 frames. Other left subframes use 11100010. Right subframes use 11100100. These half-cell patterns apply when the line is low before the preamble and are inverted when it is high.
- R6: When `fmt` is 0 or 3 (left-justified), the sample MSB is on the first bit-clock rise after a word-select change.
- R7: When `fmt` is 1 (I2S), the sample MSB is on the second bit-clock rise after a word-select change.
- R8: When `fmt` is 2 (right-justified), the sample LSB is on the last bit-clock rise before a word-select change.
- R9: `wsel` values 0, 1, 2 and 3 select widths of 16, 18, 20 and 24 bits. The sample is left-aligned in the 24-bit field, and the unused low bits are 0.
- R10: Word-select low carries the left channel, which is sent in the first subframe of a frame. Word-select high carries the right channel, which is sent in the second subframe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hc_tick | input | 1 | Half-cell strobe at 128 times the frame rate |
| sclk | input | 1 | Serial input bit clock, sampled by clk |
| lrclk | input | 1 | Word select: low means left, high means right |
| sdata | input | 1 | Serial audio data, MSB first |
| fmt | input | 2 | Input framing: 0/3 left-justified, 1 I2S, 2 right-justified |
| wsel | input | 2 | Word width: 0=16, 1=18, 2=20, 3=24 |
| bmc_out | output | 1 | Biphase-mark coded output line |

## Verification
The assertions rely on `sclk`, `lrclk` and `sdata` being synchronous to `clk`. Each bit-clock level must last at least one clock, and data and word-select must stay stable across a rise. They also rely on `hc_tick` being a single-cycle strobe that is never high two cycles in a row. The stimulus meets these conditions by construction. It drives one serial bit every four clocks, with the bit clock low for two clocks and high for two, changing data only while the bit clock is low. It raises `hc_tick` every other clock, and it holds 32 bit clocks per channel so that every word width fits in every framing.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
    localparam int AUDIO_BITS = 24;
    localparam int SUB_SLOTS  = 32;
    localparam int HC_W       = 7;

    typedef enum logic [1:0] {
        FMT_LJ     = 2'd0,
        FMT_I2S    = 2'd1,
        FMT_RJ     = 2'd2,
        FMT_LJ_ALT = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_PREAMBLE = 2'd0,
        ST_AUDIO    = 2'd1,
        ST_FLAGS    = 2'd2
    } tx_state_e;

    function automatic logic [5:0] width_of(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 6'd16;
            2'd1:    return 6'd18;
            2'd2:    return 6'd20;
            default: return 6'd24;
        endcase
    endfunction
endpackage

// File: rtl/bmc_deser.sv
module bmc_deser
    import bmc_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  lrclk,
    input  logic                  sdata,
    input  logic [1:0]            fmt,
    input  logic [1:0]            wsel,
    output logic [AUDIO_BITS-1:0] left_q,
    output logic [AUDIO_BITS-1:0] right_q
);
    logic                  sclk_d;
    logic                  ws_d;
    logic [AUDIO_BITS-1:0] shreg;
    logic [CNT_W-1:0]      cnt;

    logic                  rise;
    logic                  ws_edge;
    logic [CNT_W-1:0]      cnt_cur;
    logic [CNT_W-1:0]      cnt_nx;
    logic [AUDIO_BITS-1:0] sh_nx;
    logic [5:0]            wlen;
    logic                  take;
    logic                  take_right;
    logic [AUDIO_BITS-1:0] src;
    logic [AUDIO_BITS-1:0] aligned;

    always_comb begin
        rise       = sclk & ~sclk_d;
        ws_edge    = lrclk != ws_d;
        cnt_cur    = ws_edge ? '0 : cnt;
        cnt_nx     = cnt_cur + 1'b1;
        sh_nx      = {shreg[AUDIO_BITS-2:0], sdata};
        wlen       = width_of(wsel);
        if (fmt_e'(fmt) == FMT_RJ) begin
            take       = ws_edge;
            src        = shreg;
            take_right = ws_d;
        end else begin
            take       = (fmt_e'(fmt) == FMT_I2S) ? (cnt_nx == CNT_W'(wlen + 6'd1))
                                                   : (cnt_nx == CNT_W'(wlen));
            src        = sh_nx;
            take_right = lrclk;
        end
        aligned = src << (6'(AUDIO_BITS) - wlen);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            ws_d    <= 1'b0;
            shreg   <= '0;
            cnt     <= '0;
            left_q  <= '0;
            right_q <= '0;
        end else begin
            sclk_d <= sclk;
            if (rise) begin
                ws_d  <= lrclk;
                shreg <= sh_nx;
                cnt   <= (cnt_cur == '1) ? cnt_cur : cnt_nx;
                if (take) begin
                    if (take_right) right_q <= aligned;
                    else            left_q  <= aligned;
                end
            end
        end
    end
endmodule

// File: rtl/bmc_framer.sv
module bmc_framer
    import bmc_pkg::*;
#(
    parameter int   FRAMES_PER_BLOCK = 192,
    parameter logic CS_BIT           = 1'b0,
    localparam int  FCW              = $clog2(FRAMES_PER_BLOCK)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hc_tick,
    input  logic [AUDIO_BITS-1:0] left_in,
    input  logic [AUDIO_BITS-1:0] right_in,
    output logic                  bmc_out,
    output tx_state_e             state,
    output logic                  half,
    output logic [FCW-1:0]        frame_idx
);
    logic [HC_W-1:0]       hc;
    logic [AUDIO_BITS-1:0] cur_l;
    logic [AUDIO_BITS-1:0] cur_r;
    logic                  pol;
    logic                  par;
    tx_state_e             state_nx;

    logic [4:0]            slot;
    logic                  right_sub;
    logic [2:0]            pat_idx;
    logic [7:0]            pat;
    logic                  pol_eff;
    logic [4:0]            aud_idx;
    logic [AUDIO_BITS-1:0] sample;
    logic                  data_bit;
    logic                  out_nx;

    assign slot      = hc[5:1];
    assign half      = hc[0];
    assign right_sub = hc[6];

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PREAMBLE: if (half && slot == 5'd3)  state_nx = ST_AUDIO;
            ST_AUDIO:    if (half && slot == 5'd27) state_nx = ST_FLAGS;
            ST_FLAGS:    if (half && slot == 5'd31) state_nx = ST_PREAMBLE;
            default:     state_nx = ST_PREAMBLE;
        endcase
    end

    // state register and frame position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_PREAMBLE;
            hc        <= '0;
            frame_idx <= '0;
            cur_l     <= '0;
            cur_r     <= '0;
        end else if (hc_tick) begin
            state <= state_nx;
            hc    <= hc + 1'b1;
            if (hc == '0) begin
                cur_l <= left_in;
                cur_r <= right_in;
            end
            if (hc == '1)
                frame_idx <= (frame_idx == FCW'(FRAMES_PER_BLOCK - 1)) ? '0 : frame_idx + 1'b1;
        end
    end

    // output decode
    always_comb begin
        sample   = right_sub ? cur_r : cur_l;
        aud_idx  = slot - 5'd4;
        pat_idx  = {slot[1:0], half};
        if (right_sub)            pat = 8'b1110_0100;
        else if (frame_idx == '0) pat = 8'b1110_1000;
        else                      pat = 8'b1110_0010;
        pol_eff  = pol;
        data_bit = 1'b0;
        out_nx   = bmc_out;
        unique case (state)
            ST_PREAMBLE: begin
                pol_eff = (pat_idx == 3'd0) ? bmc_out : pol;
                out_nx  = pat[~pat_idx] ^ pol_eff;
            end
            ST_AUDIO: begin
                data_bit = sample[aud_idx];
                out_nx   = half ? (bmc_out ^ data_bit) : ~bmc_out;
            end
            ST_FLAGS: begin
                unique case (slot[1:0])
                    2'd0:    data_bit = 1'b0;
                    2'd1:    data_bit = 1'b0;
                    2'd2:    data_bit = CS_BIT;
                    default: data_bit = par;
                endcase
                out_nx = half ? (bmc_out ^ data_bit) : ~bmc_out;
            end
            default: out_nx = bmc_out;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bmc_out <= 1'b0;
            pol     <= 1'b0;
            par     <= 1'b0;
        end else if (hc_tick) begin
            bmc_out <= out_nx;
            if (state == ST_PREAMBLE)
                pol <= pol_eff;
            if (state != ST_PREAMBLE && half) begin
                if (slot == 5'd4)       par <= data_bit;
                else if (slot != 5'd31) par <= par ^ data_bit;
            end
        end
    end
endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
    import bmc_pkg::*;
#(
    parameter int   FRAMES_PER_BLOCK = 192,
    parameter logic CS_BIT           = 1'b0,
    parameter int   CNT_W            = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hc_tick,
    input  logic       sclk,
    input  logic       lrclk,
    input  logic       sdata,
    input  logic [1:0] fmt,
    input  logic [1:0] wsel,
    output logic       bmc_out
);
    localparam int FCW = $clog2(FRAMES_PER_BLOCK);

    logic [AUDIO_BITS-1:0] left_q;
    logic [AUDIO_BITS-1:0] right_q;
    tx_state_e             fr_state;
    logic                  fr_half;
    logic [FCW-1:0]        fr_frame;

    bmc_deser #(.CNT_W(CNT_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .lrclk(lrclk), .sdata(sdata),
        .fmt(fmt), .wsel(wsel), .left_q(left_q), .right_q(right_q)
    );

    bmc_framer #(.FRAMES_PER_BLOCK(FRAMES_PER_BLOCK), .CS_BIT(CS_BIT)) u_framer (
        .clk(clk), .rst_n(rst_n), .hc_tick(hc_tick), .left_in(left_q), .right_in(right_q),
        .bmc_out(bmc_out), .state(fr_state), .half(fr_half), .frame_idx(fr_frame)
    );
endmodule

// File: rtl/bmc_audio_tx_chk.sv
module bmc_audio_tx_chk
    import bmc_pkg::*;
#(
    parameter int FRAMES_PER_BLOCK = 192,
    parameter int FCW              = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  hc_tick,
    input logic                  sclk,
    input logic                  bmc_out,
    input tx_state_e             fr_state,
    input logic                  fr_half,
    input logic [FCW-1:0]        fr_frame,
    input logic [AUDIO_BITS-1:0] left_q,
    input logic [AUDIO_BITS-1:0] right_q
);
    AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !hc_tick |=> $stable(bmc_out)); // R2

    AST_CELL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (hc_tick && fr_state != ST_PREAMBLE && !fr_half) |=> (bmc_out != $past(bmc_out))); // R3

    AST_BLOCK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fr_frame) < FRAMES_PER_BLOCK); // R5

    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk |=> ($stable(left_q) && $stable(right_q))); // R6
endmodule

bind bmc_audio_tx bmc_audio_tx_chk #(.FRAMES_PER_BLOCK(FRAMES_PER_BLOCK), .FCW(FCW)) i_chk (
    .clk(clk), .rst_n(rst_n), .hc_tick(hc_tick), .sclk(sclk), .bmc_out(bmc_out),
    .fr_state(fr_state), .fr_half(fr_half), .fr_frame(fr_frame),
    .left_q(left_q), .right_q(right_q)
);

// File: tb/test_bmc_audio_tx.sv
module test_bmc_audio_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hc_tick = 1'b0;
    logic       sclk = 1'b0;
    logic       lrclk = 1'b0;
    logic       sdata = 1'b0;
    logic [1:0] fmt = 2'd0;
    logic [1:0] wsel = 2'd3;
    logic       bmc_out;

    int errors = 0;
    int checks = 0;
    int frames_done = 0;
    int frame_no = 0;
    bit settled = 1'b0;
    bit finished = 1'b0;
    bit running = 1'b0;
    logic [23:0] val_l = 24'd0;
    logic [23:0] val_r = 24'd0;
    logic        buf_hc [0:127];
    logic        last_lvl = 1'b0;

    always #4 clk = ~clk;

    bmc_audio_tx i_bmc_audio_tx (
        .clk(clk), .rst_n(rst_n), .hc_tick(hc_tick), .sclk(sclk), .lrclk(lrclk),
        .sdata(sdata), .fmt(fmt), .wsel(wsel), .bmc_out(bmc_out)
    );

    function automatic int wid(input logic [1:0] s);
        return (s == 2'd0) ? 16 : (s == 2'd1) ? 18 : (s == 2'd2) ? 20 : 24;
    endfunction

    function automatic logic [23:0] expect24(input logic [23:0] v, input int w);
        logic [31:0] m;
        m = (32'd1 << w) - 32'd1;
        return 24'(({8'd0, v} & m) << (24 - w));
    endfunction

    function automatic logic ser_bit(input logic [1:0] f, input int w, input logic [23:0] v, input int p);
        if (f == 2'd1) return (p >= 1 && p <= w) ? v[w - p] : 1'b0;
        if (f == 2'd2) return (p >= 32 - w) ? v[31 - p] : 1'b0;
        return (p < w) ? v[w - 1 - p] : 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic analyze_sub(input int s, input logic lv);
        int base;
        logic [7:0] pat;
        logic [7:0] got;
        logic [31:0] bits;
        int bad_edge;
        logic prev;
        logic [23:0] exp_v;
        int ones;
        base = s * 64;
        if (s == 1)                  pat = 8'b1110_0100;
        else if (frame_no % 192 == 0) pat = 8'b1110_1000;
        else                         pat = 8'b1110_0010;
        for (int i = 0; i < 8; i++) got[7 - i] = buf_hc[base + i];
        check(got == (pat ^ {8{lv}}), (frame_no == 0) ? "R1 R5 preamble" : "R5 preamble",
              int'(got), int'(pat ^ {8{lv}}));
        bad_edge = 0;
        prev = buf_hc[base + 7];
        bits = '0;
        for (int k = 4; k < 32; k++) begin
            if (buf_hc[base + 2 * k] == prev) bad_edge++;
            bits[k] = buf_hc[base + 2 * k] != buf_hc[base + 2 * k + 1];
            prev = buf_hc[base + 2 * k + 1];
        end
        check(bad_edge == 0, "R3 cell-start transition", bad_edge, 0);
        ones = $countones(bits);
        check(ones % 2 == 0, "R4 even parity", ones, 0);
        check(bits[30:28] == 3'b000, "R4 flag bits V U C", int'(bits[30:28]), 0);
        if (settled) begin
            exp_v = expect24((s == 0) ? val_l : val_r, wid(wsel));
            check(bits[27:4] == exp_v,
                  (fmt == 2'd1) ? ((s == 0) ? "R7 R9 R10 left audio" : "R7 R9 R10 right audio") :
                  (fmt == 2'd2) ? ((s == 0) ? "R8 R9 R10 left audio" : "R8 R9 R10 right audio") :
                                  ((s == 0) ? "R6 R9 R10 left audio" : "R6 R9 R10 right audio"),
                  int'(bits[27:4]), int'(exp_v));
        end
    endtask

    // stimulus and monitor, both on the falling edge
    initial begin
        int cyc;
        int hc;
        cyc = 0;
        hc = 0;
        forever begin
            @(negedge clk);
            if (running) begin
                if (hc_tick) begin
                    buf_hc[hc] = bmc_out;
                    hc++;
                    if (hc == 128) begin
                        analyze_sub(0, last_lvl);
                        analyze_sub(1, buf_hc[63]);
                        check(hc == 128, "R2 half-cells per frame", hc, 128);
                        last_lvl = buf_hc[127];
                        hc = 0;
                        frame_no++;
                        frames_done++;
                    end
                end
                hc_tick = (cyc % 2 == 0);
            end
            begin
                int b;
                int p;
                b = (cyc / 4) % 64;
                p = b % 32;
                sclk = (cyc % 4) >= 2;
                if (cyc % 4 == 0) begin
                    lrclk = (b >= 32);
                    sdata = ser_bit(fmt, wid(wsel), (b >= 32) ? val_r : val_l, p);
                end
            end
            cyc++;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(bmc_out == 1'b0, "R1 reset level", int'(bmc_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bmc_out == 1'b0, "R1 idle before first tick", int'(bmc_out), 0);
        @(posedge clk);
        check(bmc_out == 1'b0, "R2 no change without tick", int'(bmc_out), 0);
        running = 1'b1;
        for (int vs = 0; vs < 4; vs++) begin
            for (int f = 0; f < 4; f++) begin
                for (int w = 0; w < 4; w++) begin
                    int target;
                    settled = 1'b0;
                    fmt = 2'(f);
                    wsel = 2'(w);
                    val_l = (vs == 0) ? 24'hFFFFFF : 24'hA53C96 ^ 24'(vs * 32'h135791 + w);
                    val_r = (vs == 0) ? 24'h000001 : ~val_l ^ 24'(f * 32'h0F0F01);
                    target = frames_done + 2;
                    wait (frames_done == target);
                    settled = 1'b1;
                    target = frames_done + 2;
                    wait (frames_done == target);
                end
            end
        end
        check(frame_no > 192, "R5 second block start reached", frame_no, 193);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", frame_no, 256);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule